// File: doc/BRIEF.md
# On-Chip Debug Control Register

This block holds the control byte of an on-chip debugger for a small 8-bit CPU. Software (or the debugger's host side) reads and writes it through a byte-wide register port. The block watches the instruction decoder for the breakpoint opcode and decides whether that opcode halts the core or runs as a no-op. While the debug flag is set, the block tells the CPU to stop fetching. When the flag drops, it sends the CPU a one-cycle restart pulse.

Hardware events also change the register. A decoded breakpoint sets the debug flag when breakpoints are enabled. A requested system reset stays pending until the reset sequencer reports completion, and then clears itself. While the read-protect option is active, software cannot leave debug mode. Only the debugger's own reset (`rst`) clears the register. A system reset that the block requests does not. When the acknowledge feature is enabled, each breakpoint raises a one-cycle request to send the acknowledge byte FFH to the host.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After `rst`, `rd_data` reads 00H, and `halt_fetch`, `cpu_restart`, `sys_rst_req` and `ack_req` are all 0.
- R2: The bit layout is bit 7 = debug flag, bit 6 = breakpoint enable, bit 5 = acknowledge enable, bit 0 = reset request. Bits 4..1 always read 0, and writing them has no effect. A write takes effect on the clock edge where `wr_en` is sampled high.
- R3: `halt_fetch` equals the debug flag. Writing 1 to bit 7 enters debug mode.
- R4: When `dec_valid` is high with `dec_opcode` = 00H and breakpoint enable is 1, the debug flag is 1 after that edge.
- R5: When breakpoint enable is 0, a decoded 00H leaves the debug flag unchanged. Any other opcode never changes it.
- R6: With `rdprot` low, writing 0 to bit 7 clears the debug flag. `cpu_restart` is high for exactly the one cycle in which `halt_fetch` first reads 0.
- R7: With `rdprot` high, a write of 0 to bit 7 leaves the debug flag at 1 and gives no `cpu_restart`. Only `rst` clears the flag.
- R8: A breakpoint hit (R4) with acknowledge enable at 1 makes `ack_req` high for one cycle, with `ack_char` = FFH. With acknowledge enable at 0, no request is made.
- R9: Writing 1 to bit 0 raises `sys_rst_req`. The request holds through writes of 0 until `sys_rst_done` is sampled high, and is 0 after that edge. `sys_rst_done` does not change bits 7..5.
- R10: If a breakpoint hit and a write of 0 to bit 7 fall in the same cycle, the debug flag ends up 1. The other written bits still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high debugger reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| dec_valid | input | 1 | Decoder has an opcode this cycle |
| dec_opcode | input | 8 | Decoded opcode |
| rdprot | input | 1 | Read-protect option active |
| sys_rst_done | input | 1 | Reset sequencer finished |
| halt_fetch | output | 1 | Stop fetching new instructions |
| cpu_restart | output | 1 | One-cycle CPU restart pulse |
| sys_rst_req | output | 1 | System reset request, debugger excluded |
| ack_req | output | 1 | One-cycle request to send the acknowledge byte |
| ack_char | output | 8 | Acknowledge byte, FFH while `ack_req` is high |

## Verification
The assertions check the following on every cycle:
- a breakpoint opcode with breakpoints enabled always halts the core on the next cycle;
- the flag cannot rise when breakpoints are disabled and no write occurs;
- read protection keeps the flag from falling;
- a restart pulse only follows a falling flag;
- the reset request holds until completion, then drops.

Only the bench scenarios can show the following:
- that reserved bits ignore writes;
- that a non-breakpoint opcode is harmless;
- the write-versus-breakpoint race;
- that the acknowledge byte value and single-cycle width match;
- that the reset request survives a cancelling write.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_DBG   = 7;
  localparam int BIT_BRKEN = 6;
  localparam int BIT_ACKEN = 5;
  localparam int BIT_RST   = 0;
  localparam int RSV_LO    = 1;
  localparam int RSV_HI    = 4;
  localparam int RSV_W     = RSV_HI - RSV_LO + 1;

  typedef struct packed {
    logic dbg;
    logic brken;
    logic acken;
    logic rst;
  } ctl_bits_t;

  function automatic logic [REG_W-1:0] pack_rd(input ctl_bits_t b);
    logic [REG_W-1:0] v;
    v            = '0;
    v[BIT_DBG]   = b.dbg;
    v[BIT_BRKEN] = b.brken;
    v[BIT_ACKEN] = b.acken;
    v[BIT_RST]   = b.rst;
    return v;
  endfunction
endpackage

// File: rtl/dbg_brk_match.sv
module dbg_brk_match #(
  parameter int          OPC_W   = 8,
  parameter logic [7:0]  BRK_OPC = 8'h00
) (
  input  logic             dec_valid,
  input  logic [OPC_W-1:0] dec_opcode,
  input  logic             brken,
  output logic             brk_hit
);
  localparam logic [OPC_W-1:0] MATCH = OPC_W'(BRK_OPC);

  always_comb begin
    brk_hit = dec_valid && (dec_opcode == MATCH) && brken;
  end
endmodule

// File: rtl/dbg_mode_flag.sv
module dbg_mode_flag (
  input  logic clk,
  input  logic rst,
  input  logic brk_hit,
  input  logic wr_en,
  input  logic wr_dbg,
  input  logic rdprot,
  output logic dbg_q,
  output logic restart_q
);
  logic dbg_d;

  always_comb begin
    dbg_d = dbg_q;
    if (wr_en) begin
      if (wr_dbg)
        dbg_d = 1'b1;
      else if (!rdprot)
        dbg_d = 1'b0;
    end
    if (brk_hit)
      dbg_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      dbg_q     <= dbg_d;
      restart_q <= dbg_q & ~dbg_d;
    end
  end
endmodule

// File: rtl/dbg_rst_bit.sv
module dbg_rst_bit (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_rst,
  input  logic done,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (rst)
      req_q <= 1'b0;
    else if (done)
      req_q <= 1'b0;
    else if (wr_en && wr_rst)
      req_q <= 1'b1;
  end
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_pkg::*;
#(
  parameter int         OPC_W    = 8,
  parameter logic [7:0] BRK_OPC  = 8'h00,
  parameter logic [7:0] ACK_CHAR = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             dec_valid,
  input  logic [OPC_W-1:0] dec_opcode,
  input  logic             rdprot,
  input  logic             sys_rst_done,
  output logic             halt_fetch,
  output logic             cpu_restart,
  output logic             sys_rst_req,
  output logic             ack_req,
  output logic [7:0]       ack_char
);
  ctl_bits_t bits;
  logic      brken_q, acken_q, brk_hit;
  logic      dbg_q, restart_q, rstreq_q;
  logic      unused_rsv;

  assign unused_rsv = ^wr_data[RSV_HI:RSV_LO];

  dbg_brk_match #(.OPC_W(OPC_W), .BRK_OPC(BRK_OPC)) u_match (
    .dec_valid (dec_valid),
    .dec_opcode(dec_opcode),
    .brken     (brken_q),
    .brk_hit   (brk_hit)
  );

  dbg_mode_flag u_mode (
    .clk      (clk),
    .rst      (rst),
    .brk_hit  (brk_hit),
    .wr_en    (wr_en),
    .wr_dbg   (wr_data[BIT_DBG]),
    .rdprot   (rdprot),
    .dbg_q    (dbg_q),
    .restart_q(restart_q)
  );

  dbg_rst_bit u_rstb (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .wr_rst(wr_data[BIT_RST]),
    .done  (sys_rst_done),
    .req_q (rstreq_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      brken_q  <= 1'b0;
      acken_q  <= 1'b0;
      ack_req  <= 1'b0;
      ack_char <= '0;
    end else begin
      if (wr_en) begin
        brken_q <= wr_data[BIT_BRKEN];
        acken_q <= wr_data[BIT_ACKEN];
      end
      ack_req  <= brk_hit & acken_q;
      ack_char <= (brk_hit & acken_q) ? ACK_CHAR : '0;
    end
  end

  always_comb begin
    bits.dbg   = dbg_q;
    bits.brken = brken_q;
    bits.acken = acken_q;
    bits.rst   = rstreq_q;
  end

  assign rd_data     = pack_rd(bits);
  assign halt_fetch  = dbg_q;
  assign cpu_restart = restart_q;
  assign sys_rst_req = rstreq_q;
endmodule

// File: rtl/dbg_ctl_reg_chk.sv
module dbg_ctl_reg_chk #(
  parameter int OPC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [7:0]       rd_data,
  input logic             dec_valid,
  input logic [OPC_W-1:0] dec_opcode,
  input logic             rdprot,
  input logic             sys_rst_done,
  input logic             halt_fetch,
  input logic             cpu_restart,
  input logic             sys_rst_req,
  input logic             ack_req
);
  p_brk_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_opcode == '0 && rd_data[6]) |=> halt_fetch);

  p_brk_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[6] && !wr_en && !halt_fetch) |=> !halt_fetch);

  p_restart_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_restart |-> (!halt_fetch && $past(halt_fetch)));

  p_prot_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rdprot && halt_fetch) |=> halt_fetch);

  p_ack_cause_r8: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> ($past(rd_data[5]) && $past(dec_valid)));

  p_rst_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_req && !sys_rst_done) |=> sys_rst_req);

  p_rst_clear_r9: assert property (@(posedge clk) disable iff (rst)
    sys_rst_done |=> !sys_rst_req);
endmodule

bind dbg_ctl_reg dbg_ctl_reg_chk #(.OPC_W(OPC_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_data(rd_data),
  .dec_valid(dec_valid), .dec_opcode(dec_opcode), .rdprot(rdprot),
  .sys_rst_done(sys_rst_done), .halt_fetch(halt_fetch),
  .cpu_restart(cpu_restart), .sys_rst_req(sys_rst_req), .ack_req(ack_req)
);

// File: tb/sim_dbg_ctl_reg.sv
module sim_dbg_ctl_reg;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       dec_valid = 1'b0;
  logic [7:0] dec_opcode = '0;
  logic       rdprot = 1'b0;
  logic       sys_rst_done = 1'b0;
  logic       halt_fetch, cpu_restart, sys_rst_req, ack_req;
  logic [7:0] ack_char;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_ctl_reg u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dec_valid(dec_valid), .dec_opcode(dec_opcode), .rdprot(rdprot),
    .sys_rst_done(sys_rst_done), .halt_fetch(halt_fetch),
    .cpu_restart(cpu_restart), .sys_rst_req(sys_rst_req),
    .ack_req(ack_req), .ack_char(ack_char)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_brk(input logic [7:0] opc);
    @(negedge clk);
    dec_valid = 1'b1; dec_opcode = opc;
    @(negedge clk);
    dec_valid = 1'b0; dec_opcode = '0;
  endtask

  task automatic do_rst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "rd_data", rd_data, 8'h00);
    chk("R1", "outputs", {4'h0, halt_fetch, cpu_restart, sys_rst_req, ack_req}, 8'h00);
  endtask

  task automatic t_layout_restart();
    do_write(8'hFE);
    chk("R2", "reserved ignored", rd_data, 8'hE0);
    chk("R3", "halt on write", {7'h0, halt_fetch}, 8'h01);
    do_write(8'h00);
    chk("R6", "halt cleared", {7'h0, halt_fetch}, 8'h00);
    chk("R6", "restart pulse", {7'h0, cpu_restart}, 8'h01);
    @(negedge clk);
    chk("R6", "restart one cycle", {7'h0, cpu_restart}, 8'h00);
  endtask

  task automatic t_brk();
    do_write(8'h40);
    do_brk(8'h12);
    chk("R5", "other opcode", {7'h0, halt_fetch}, 8'h00);
    do_brk(8'h00);
    chk("R4", "brk halts", {7'h0, halt_fetch}, 8'h01);
    chk("R8", "no ack when disabled", {7'h0, ack_req}, 8'h00);
    do_write(8'h00);
    do_brk(8'h00);
    chk("R5", "brk as no-op", rd_data, 8'h00);
  endtask

  task automatic t_ack();
    do_write(8'h60);
    do_brk(8'h00);
    chk("R8", "ack pulse", {7'h0, ack_req}, 8'h01);
    chk("R8", "ack char", ack_char, 8'hFF);
    chk("R4", "flag set", rd_data, 8'hE0);
    @(negedge clk);
    chk("R8", "ack one cycle", {7'h0, ack_req}, 8'h00);
    do_write(8'h00);
  endtask

  task automatic t_prot();
    rdprot = 1'b1;
    do_write(8'hC0);
    do_write(8'h40);
    chk("R7", "flag held", rd_data, 8'hC0);
    chk("R7", "no restart", {7'h0, cpu_restart}, 8'h00);
    do_rst();
    chk("R7", "rst clears", rd_data, 8'h00);
    rdprot = 1'b0;
  endtask

  task automatic t_race();
    do_write(8'hC0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h60; dec_valid = 1'b1; dec_opcode = 8'h00;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; dec_valid = 1'b0;
    chk("R10", "hw set wins", rd_data, 8'hE0);
    chk("R10", "no restart", {7'h0, cpu_restart}, 8'h00);
    do_write(8'h00);
  endtask

  task automatic t_sysrst();
    do_write(8'h41);
    chk("R9", "req raised", {7'h0, sys_rst_req}, 8'h01);
    repeat (3) @(negedge clk);
    do_write(8'h40);
    chk("R9", "req held", rd_data, 8'h41);
    @(negedge clk); sys_rst_done = 1'b1;
    @(negedge clk); sys_rst_done = 1'b0;
    chk("R9", "req cleared", {7'h0, sys_rst_req}, 8'h00);
    chk("R9", "other bits kept", rd_data, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout_restart();
    t_brk();
    t_ack();
    t_prot();
    t_race();
    t_sysrst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule